// File: doc/BRIEF.md
# Post-Update Shifted Load Unit

This block is the execute and writeback stage for a family of 64-bit indexed loads that use post-update addressing. It accepts one decoded load operation at a time. The operation carries an access size, a signed flag, the base and target register indices, the base and index operand values, and a 2-bit shift field. The unit computes the access address by shifting the base operand left by one more than the shift field. The index operand takes no part in that address. The unit then issues one read request on a valid/ready memory port.

When the memory returns data, the unit picks the low 8, 16, 32 or 64 bits of the right-aligned response and extends the result to 64 bits. On the following cycle it presents two register-file writes at the same time. The target register receives the loaded value. The base register receives the sum of the original base and index operands.

An operation is an illegal form when its base index is zero or equal to its target index. Such an operation is flagged, sends no memory request and performs neither register write. No other architectural state is touched.

Top module: `psload_unit`

## Requirements
- R1: For an accepted legal operation, the address on `mem_req_addr` equals the base operand shifted left by (shift field + 1) positions in 64 bits. Bits shifted past the top are lost. A shift field of 3 gives a shift of 4. The index operand has no effect on the address.
- R2: The base writeback data `ra_wdata` equals the original base operand plus the index operand, modulo 2^64.
- R3: Size code 0 (byte) writes the low 8 bits of the response to the target register with bits 63..8 cleared, whatever the signed flag.
- R4: Size code 1 (halfword) writes the low 16 bits. Bits 63..16 are zero when the signed flag is 0, and copies of response bit 15 when it is 1.
- R5: Size code 2 (word) writes the low 32 bits. Bits 63..32 are zero when the signed flag is 0, and copies of response bit 31 when it is 1.
- R6: Size code 3 (doubleword) writes all 64 response bits unchanged, whatever the signed flag. `mem_req_size` carries the operation's size code.
- R7: An operation whose base index is 0 or equals its target index raises `invalid_form` for exactly one cycle, the cycle after acceptance. It issues no memory request and causes no register write.
- R8: `rt_we` and `ra_we` rise together for one cycle, the cycle after the memory response is accepted. `rt_waddr` and `ra_waddr` then carry the operation's target and base indices.
- R9: `busy` is high and `op_ready` low from the cycle after a legal operation is accepted until its writeback cycle. Operations offered during that window are ignored. A pending request holds its address stable until `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit can accept an operation this cycle |
| op_size | input | 2 | Access size code: 0 byte, 1 half, 2 word, 3 double |
| op_signed | input | 1 | Sign-extend halfword/word results |
| op_ra_idx | input | 5 | Base register index |
| op_rt_idx | input | 5 | Target register index |
| op_ra_val | input | 64 | Base operand value |
| op_rb_val | input | 64 | Index operand value |
| op_sh | input | 2 | Shift field; address shift is this plus one |
| busy | output | 1 | An operation is in flight |
| invalid_form | output | 1 | One-cycle pulse for an illegal operation |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Read address |
| mem_req_size | output | 2 | Read size code |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data, right-aligned |
| rt_we | output | 1 | Target register write enable |
| rt_waddr | output | 5 | Target register index |
| rt_wdata | output | 64 | Loaded, extended value |
| ra_we | output | 1 | Base register write enable |
| ra_waddr | output | 5 | Base register index |
| ra_wdata | output | 64 | Updated base value |

## Verification
The assertions check several rules on every cycle. The two write enables always move together. A write never targets index zero or a base equal to the target. A write only follows an accepted response. An illegal-form pulse never coincides with a write. A stalled request keeps its address. An accepted operation always leads to either busy or the illegal-form pulse. The actual arithmetic is shown only by the bench's sweeps: the shifted address, the post-update sum, and the zero or sign extension for each size and flag. The same holds for ignoring an operation offered while busy.

// File: rtl/psload_pkg.sv
package psload_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_RSP  = 2'd2
  } state_e;
endpackage

// File: rtl/psload_agen.sv
module psload_agen #(
  parameter int XLEN = 64,
  parameter int SHW  = 2
) (
  input  logic [XLEN-1:0] base,
  input  logic [XLEN-1:0] index,
  input  logic [SHW-1:0]  sh,
  output logic [XLEN-1:0] ea,
  output logic [XLEN-1:0] upd
);
  localparam int AW = SHW + 1;

  // one extra bit so that the largest field value does not wrap to zero
  logic [AW-1:0] amount;

  assign amount = {1'b0, sh} + AW'(1);
  assign ea     = base << amount;
  assign upd    = base + index;
endmodule

// File: rtl/psload_extend.sv
module psload_extend
  import psload_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] raw,
  input  size_e           size,
  input  logic            sgn,
  output logic [XLEN-1:0] result
);
  localparam int NSZ = 4;

  logic [XLEN-1:0] lane [NSZ];
  logic            sgn_eff;

  // sign extension only exists for the halfword and word forms
  assign sgn_eff = sgn && ((size == SZ_HALF) || (size == SZ_WORD));

  for (genvar k = 0; k < NSZ; k++) begin : g_lane
    localparam int W = 8 << k;
    if (W >= XLEN) begin : g_full
      assign lane[k] = raw;
    end else begin : g_part
      assign lane[k] = {{(XLEN-W){sgn_eff & raw[W-1]}}, raw[W-1:0]};
    end
  end

  assign result = lane[size];
endmodule

// File: rtl/psload_ctrl.sv
module psload_ctrl
  import psload_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   op_valid,
  input  logic   form_bad,
  input  logic   mem_req_ready,
  input  logic   mem_rsp_valid,
  output state_e state,
  output logic   accept,
  output logic   take_op,
  output logic   rsp_take
);
  state_e nxt;

  assign accept   = op_valid && (state == ST_IDLE);
  assign take_op  = accept && !form_bad;
  assign rsp_take = (state == ST_RSP) && mem_rsp_valid;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (take_op)       nxt = ST_REQ;
      ST_REQ:  if (mem_req_ready) nxt = ST_RSP;
      ST_RSP:  if (mem_rsp_valid) nxt = ST_IDLE;
      default:                    nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/psload_unit.sv
module psload_unit
  import psload_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int REGW = 5,
  parameter int SHW  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [1:0]      op_size,
  input  logic            op_signed,
  input  logic [REGW-1:0] op_ra_idx,
  input  logic [REGW-1:0] op_rt_idx,
  input  logic [XLEN-1:0] op_ra_val,
  input  logic [XLEN-1:0] op_rb_val,
  input  logic [SHW-1:0]  op_sh,
  output logic            busy,
  output logic            invalid_form,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XLEN-1:0] mem_req_addr,
  output logic [1:0]      mem_req_size,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_data,
  output logic            rt_we,
  output logic [REGW-1:0] rt_waddr,
  output logic [XLEN-1:0] rt_wdata,
  output logic            ra_we,
  output logic [REGW-1:0] ra_waddr,
  output logic [XLEN-1:0] ra_wdata
);
  state_e          state;
  logic            accept, take_op, rsp_take, form_bad;
  logic [XLEN-1:0] ea_c, upd_c, ext_c;
  logic [XLEN-1:0] ea_q, upd_q;
  size_e           size_q;
  logic            sgn_q;
  logic [REGW-1:0] rt_q, ra_q;

  assign form_bad = (op_ra_idx == '0) || (op_ra_idx == op_rt_idx);

  psload_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .op_valid      (op_valid),
    .form_bad      (form_bad),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .state         (state),
    .accept        (accept),
    .take_op       (take_op),
    .rsp_take      (rsp_take)
  );

  psload_agen #(.XLEN(XLEN), .SHW(SHW)) u_agen (
    .base  (op_ra_val),
    .index (op_rb_val),
    .sh    (op_sh),
    .ea    (ea_c),
    .upd   (upd_c)
  );

  psload_extend #(.XLEN(XLEN)) u_ext (
    .raw    (mem_rsp_data),
    .size   (size_q),
    .sgn    (sgn_q),
    .result (ext_c)
  );

  assign op_ready      = (state == ST_IDLE);
  assign busy          = (state != ST_IDLE);
  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_addr  = ea_q;
  assign mem_req_size  = size_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_q         <= '0;
      upd_q        <= '0;
      size_q       <= SZ_BYTE;
      sgn_q        <= 1'b0;
      rt_q         <= '0;
      ra_q         <= '0;
      invalid_form <= 1'b0;
      rt_we        <= 1'b0;
      ra_we        <= 1'b0;
      rt_waddr     <= '0;
      ra_waddr     <= '0;
      rt_wdata     <= '0;
      ra_wdata     <= '0;
    end else begin
      invalid_form <= accept && form_bad;
      rt_we        <= rsp_take;
      ra_we        <= rsp_take;
      if (take_op) begin
        ea_q   <= ea_c;
        upd_q  <= upd_c;
        size_q <= size_e'(op_size);
        sgn_q  <= op_signed;
        rt_q   <= op_rt_idx;
        ra_q   <= op_ra_idx;
      end
      if (rsp_take) begin
        rt_wdata <= ext_c;
        ra_wdata <= upd_q;
        rt_waddr <= rt_q;
        ra_waddr <= ra_q;
      end
    end
  end
endmodule

// File: rtl/psload_chk.sv
module psload_chk #(
  parameter int XLEN = 64,
  parameter int REGW = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            op_valid,
  input logic            op_ready,
  input logic            busy,
  input logic            invalid_form,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [XLEN-1:0] mem_req_addr,
  input logic            mem_rsp_valid,
  input logic            rt_we,
  input logic            ra_we,
  input logic [REGW-1:0] rt_waddr,
  input logic [REGW-1:0] ra_waddr
);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_accept_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_ready) |=> (busy || invalid_form));

  assert_no_write_invalid_R7: assert property (@(posedge clk) disable iff (rst)
    invalid_form |-> (!rt_we && !ra_we));

  assert_legal_index_R7: assert property (@(posedge clk) disable iff (rst)
    rt_we |-> ((ra_waddr != '0) && (ra_waddr != rt_waddr)));

  assert_paired_write_R8: assert property (@(posedge clk) disable iff (rst)
    (rt_we || ra_we) |-> (rt_we && ra_we));

  assert_write_after_rsp_R8: assert property (@(posedge clk) disable iff (rst)
    rt_we |-> ($past(mem_rsp_valid) && $past(busy)));
endmodule

bind psload_unit psload_chk #(.XLEN(XLEN), .REGW(REGW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .op_valid      (op_valid),
  .op_ready      (op_ready),
  .busy          (busy),
  .invalid_form  (invalid_form),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .rt_we         (rt_we),
  .ra_we         (ra_we),
  .rt_waddr      (rt_waddr),
  .ra_waddr      (ra_waddr)
);

// File: tb/psload_unit_tb.sv
module psload_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid, op_ready, op_signed;
  logic [1:0]  op_size, op_sh;
  logic [4:0]  op_ra_idx, op_rt_idx;
  logic [63:0] op_ra_val, op_rb_val;
  logic        busy, invalid_form, mem_req_valid, mem_req_ready, mem_rsp_valid;
  logic [63:0] mem_req_addr, mem_rsp_data;
  logic [1:0]  mem_req_size;
  logic        rt_we, ra_we;
  logic [4:0]  rt_waddr, ra_waddr;
  logic [63:0] rt_wdata, ra_wdata;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psload_unit u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_size(op_size), .op_signed(op_signed), .op_ra_idx(op_ra_idx),
    .op_rt_idx(op_rt_idx), .op_ra_val(op_ra_val), .op_rb_val(op_rb_val),
    .op_sh(op_sh), .busy(busy), .invalid_form(invalid_form),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rt_we(rt_we), .rt_waddr(rt_waddr), .rt_wdata(rt_wdata),
    .ra_we(ra_we), .ra_waddr(ra_waddr), .ra_wdata(ra_wdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ext_exp(input logic [1:0] sz, input bit sg,
                                          input logic [63:0] d);
    case (sz)
      2'd0:    return d & 64'hFF;
      2'd1:    return (sg && d[15]) ? (d | ~64'hFFFF) : (d & 64'hFFFF);
      2'd2:    return (sg && d[31]) ? (d | ~64'hFFFF_FFFF) : (d & 64'hFFFF_FFFF);
      default: return d;
    endcase
  endfunction

  task automatic run_op(input logic [1:0] sz, input bit sg, input logic [4:0] ra_i,
                        input logic [4:0] rt_i, input logic [63:0] ra_v,
                        input logic [63:0] rb_v, input logic [1:0] sh,
                        input logic [63:0] data, input int stall, input int lat,
                        input bit intrude);
    logic [63:0] exp_ea;
    bit bad;
    string rq;
    bad    = (ra_i == 5'd0) || (ra_i == rt_i);
    exp_ea = ra_v << (int'(sh) + 1);
    @(negedge clk);
    op_valid = 1'b1; op_size = sz; op_signed = sg; op_ra_idx = ra_i;
    op_rt_idx = rt_i; op_ra_val = ra_v; op_rb_val = rb_v; op_sh = sh;
    @(negedge clk);
    op_valid = 1'b0;
    if (bad) begin
      chk(invalid_form === 1'b1, "R7 invalid pulse", 64'(invalid_form), 64'd1);
      chk(!rt_we && !ra_we, "R7 no write", 64'({rt_we, ra_we}), 64'd0);
      chk(mem_req_valid === 1'b0, "R7 no request", 64'(mem_req_valid), 64'd0);
      @(negedge clk);
      chk(invalid_form === 1'b0, "R7 pulse one cycle", 64'(invalid_form), 64'd0);
      chk(!rt_we && !ra_we && !mem_req_valid, "R7 still idle",
          64'({rt_we, ra_we, mem_req_valid}), 64'd0);
      return;
    end
    chk(invalid_form === 1'b0, "R7 legal not flagged", 64'(invalid_form), 64'd0);
    chk(mem_req_valid === 1'b1, "R9 request raised", 64'(mem_req_valid), 64'd1);
    chk(busy === 1'b1 && op_ready === 1'b0, "R9 busy", 64'({busy, op_ready}), 64'b10);
    chk(mem_req_addr === exp_ea, "R1 address", mem_req_addr, exp_ea);
    chk(mem_req_size === sz, "R6 request size", 64'(mem_req_size), 64'(sz));
    if (intrude) begin
      op_valid = 1'b1; op_ra_idx = 5'd9; op_rt_idx = 5'd10;
      op_ra_val = ~ra_v; op_rb_val = 64'd5; op_size = ~sz; op_sh = ~sh;
    end
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(mem_req_valid === 1'b1 && mem_req_addr === exp_ea, "R9 request held",
          mem_req_addr, exp_ea);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk(mem_req_valid === 1'b0 && busy === 1'b1, "R9 waiting for data",
        64'({mem_req_valid, busy}), 64'b01);
    for (int i = 0; i < lat; i++) @(negedge clk);
    op_valid = 1'b0;
    mem_rsp_valid = 1'b1; mem_rsp_data = data;
    chk(rt_we === 1'b0, "R8 no early write", 64'(rt_we), 64'd0);
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = 64'hDEAD_BEEF_DEAD_BEEF;
    case (sz)
      2'd0: rq = "R3 byte data";
      2'd1: rq = "R4 halfword data";
      2'd2: rq = "R5 word data";
      default: rq = "R6 doubleword data";
    endcase
    chk(rt_we === 1'b1 && ra_we === 1'b1, "R8 paired enables", 64'({rt_we, ra_we}), 64'b11);
    chk(rt_waddr === rt_i && ra_waddr === ra_i, "R8 write indices",
        64'({rt_waddr, ra_waddr}), 64'({rt_i, ra_i}));
    chk(rt_wdata === ext_exp(sz, sg, data), rq, rt_wdata, ext_exp(sz, sg, data));
    chk(ra_wdata === ra_v + rb_v, "R2 post-update", ra_wdata, ra_v + rb_v);
    chk(busy === 1'b0, "R9 busy released", 64'(busy), 64'd0);
    @(negedge clk);
    chk(!rt_we && !ra_we && !mem_req_valid, "R8 single write cycle",
        64'({rt_we, ra_we, mem_req_valid}), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] ras [3];
    logic [63:0] dats [3];
    int n;
    ras[0]  = 64'h0000_0000_0001_2345;
    ras[1]  = 64'hC000_0000_0000_0003;
    ras[2]  = 64'h7FFF_FFFF_FFFF_FFFF;
    dats[0] = 64'h0123_4567_89AB_CDEF;
    dats[1] = 64'hFEDC_BA98_7654_3270;
    dats[2] = 64'h8000_0000_7F80_8000;
    rst = 1'b1; op_valid = 1'b0; op_size = '0; op_signed = 1'b0; op_ra_idx = '0;
    op_rt_idx = '0; op_ra_val = '0; op_rb_val = '0; op_sh = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    chk(!busy && op_ready && !mem_req_valid && !rt_we && !ra_we && !invalid_form,
        "R9 reset state", 64'({busy, op_ready, mem_req_valid, rt_we, ra_we, invalid_form}),
        64'b010000);
    rst = 1'b0;
    n = 0;
    for (int s = 0; s < 4; s++)
      for (int g = 0; g < 2; g++)
        for (int h = 0; h < 4; h++)
          for (int a = 0; a < 3; a++)
            for (int d = 0; d < 3; d++) begin
              logic [4:0] ra_i, rt_i;
              ra_i = 5'(1 + (n % 31));
              rt_i = 5'((int'(ra_i) + 1 + (n % 7)) % 32);
              run_op(2'(s), g[0], ra_i, rt_i, ras[a],
                     64'hFFFF_FFFF_FFFF_FFF0 + 64'(n), 2'(h), dats[d],
                     n % 3, n % 2, (n % 5) == 0);
              n++;
            end
    // illegal forms: base index zero, and base equal to target
    run_op(2'd3, 1'b0, 5'd0, 5'd4, 64'h10, 64'h1, 2'd0, dats[0], 0, 0, 1'b0);
    run_op(2'd1, 1'b1, 5'd7, 5'd7, 64'h10, 64'h1, 2'd1, dats[0], 0, 0, 1'b0);
    run_op(2'd0, 1'b0, 5'd0, 5'd0, 64'h10, 64'h1, 2'd2, dats[0], 0, 0, 1'b0);
    // legal right after an illegal one, target index zero
    run_op(2'd2, 1'b1, 5'd31, 5'd0, 64'h8000_0000_0000_0001, 64'h1, 2'd3,
           dats[0], 1, 1, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule